// File: doc/BRIEF.md
# Nonrestoring Divide Step Unit

This block performs unsigned division one bit per clock using a nonrestoring add/subtract recurrence. It holds a shift register for the quotient (`q`), a direction flag `df` and a sign flag `n`. Software, or any sequencer, issues single steps through a strobe with a two-bit step type. An initial step seeds the flags and moves the top dividend bit into the partial remainder. Each middle step adds or subtracts the divisor, as `df` selects, and shifts one quotient bit into `q`. A last step leaves the remainder unshifted. A correction step then repairs a negative remainder. The flags and `q` can also be written directly through a special-register write port.

A built-in sequencer runs a complete division when fed through a valid/ready stream. It takes a dividend and a divisor on the input channel. It then issues one initial step with a zero high word, W-1 middle steps, one last step and one correction step. It offers the quotient (from `q`) and the remainder (from `res`) on the output channel. The output holds until the consumer takes it, and no new operand is accepted until then. A zero divisor gives an unspecified quotient and remainder.

Top module: `dstep_unit`

## Requirements
- R1: After reset, `res`, `q`, `df` and `n` are zero, `in_ready` is 1 and `out_valid` is 0.
- R2: An accepted step with `step_kind`=0 (initial) sets `df`=1 and `n`=`op_b[W-1]`. It loads `res` with `{op_b[W-2:0], q[W-1]}` and shifts `q` left with 0 entering bit 0. All outputs change after the rising edge that samples the strobe.
- R3: An accepted step with `step_kind`=1 (middle) forms `sum = op_a + t`, where `t` is `-op_b` when `df`=1 and `op_b` otherwise. The new `df` is the old `df`, inverted once if that addition carries nothing out of bit W-1, and inverted once more if the old `n` was 1. `n` becomes `sum[W-1]` and `res` becomes `{sum[W-2:0], old q[W-1]}`. `q` shifts left with the new `df` entering bit 0.
- R4: An accepted step with `step_kind`=2 (last) updates `df`, `n` and `q` exactly as R3 does, but loads `res` with the unshifted `sum`.
- R5: An accepted step with `step_kind`=3 (correction) loads `res` with `op_a` when `df`=1 and with `op_a + op_b` otherwise. It leaves `q`, `df` and `n` unchanged.
- R6: A special-register write with `sr_sel`=0 loads `q` from `sr_wdata`. With `sr_sel`=1 it loads `df` from bit 0 and `n` from bit 1. A write takes priority over a step strobe in the same cycle, and that step is dropped entirely.
- R7: Without a strobe, a write or a division, `res`, `q`, `df` and `n` hold their values whatever `op_a`, `op_b` and `step_kind` do.
- R8: An input transfer (`in_valid` and `in_ready` both high at a rising edge) starts a division. `out_valid` rises after the (W+2)th following rising edge, with `out_quot` = dividend / divisor and `out_rem` = dividend mod divisor for any non-zero divisor.
- R9: `out_valid`, `out_quot` and `out_rem` hold steady until a rising edge with `out_ready` high, after which `in_ready` returns to 1. `in_ready` stays 0 from the input transfer until that edge.
- R10: While `in_ready` is 0, or in the cycle of an input transfer, step strobes and special-register writes have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step_req | input | 1 | Strobe: perform one step this cycle |
| step_kind | input | 2 | 0 initial, 1 middle, 2 last, 3 correction |
| op_a | input | W | Partial remainder operand |
| op_b | input | W | Divisor or dividend high word operand |
| sr_we | input | 1 | Special-register write strobe |
| sr_sel | input | 1 | 0 selects `q`, 1 selects the flags |
| sr_wdata | input | W | Write data (flags: bit 0 `df`, bit 1 `n`) |
| res | output | W | Step result register |
| q | output | W | Quotient shift register |
| df | output | 1 | Direction flag |
| n | output | 1 | Sign flag |
| in_valid | input | 1 | Operand channel valid |
| in_ready | output | 1 | Operand channel ready (unit idle) |
| in_dividend | input | W | Dividend |
| in_divisor | input | W | Divisor |
| out_valid | output | 1 | Result channel valid |
| out_ready | input | 1 | Result channel ready |
| out_quot | output | W | Quotient |
| out_rem | output | W | Remainder |

## Verification
The middle step is driven with every combination of `df` and `n` preloaded, so each flip of the toggle rule (carry alone, sign alone, both, neither) shows up in `df` and in the new `q` bit. Full divisions run with small, maximal and top-bit-set divisors and with dividends below and above the divisor, because those stress the carry-free path and the case where `n` is carried into the next step. The same divisions are also run by hand through single steps to confirm the step types compose. The stream is tried with delayed `out_ready` and with strobes and writes injected mid-division, to separate back-pressure handling from ignored stimulus.

// File: rtl/dstep_pkg.sv
package dstep_pkg;

  typedef enum logic [1:0] {
    STEP_INIT = 2'd0,
    STEP_MID  = 2'd1,
    STEP_LAST = 2'd2,
    STEP_FIX  = 2'd3
  } step_kind_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_INIT,
    SQ_MID,
    SQ_LAST,
    SQ_FIX,
    SQ_DONE
  } seq_state_e;

  // special-register select and flag bit positions in write data
  localparam logic SR_SEL_Q     = 1'b0;
  localparam logic SR_SEL_FLAGS = 1'b1;
  localparam int   FLAG_DF_BIT  = 0;
  localparam int   FLAG_N_BIT   = 1;

endpackage

// File: rtl/dstep_alu.sv
module dstep_alu
  import dstep_pkg::*;
#(
  parameter int W = 32
) (
  input  step_kind_e   kind,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] q,
  input  logic         df,
  input  logic         n,
  output logic [W-1:0] res_nxt,
  output logic [W-1:0] q_nxt,
  output logic         df_nxt,
  output logic         n_nxt
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] addend;
  logic [W-1:0] sum;
  logic [W-1:0] fix_sum;
  logic         carry;
  logic         df_step;

  always_comb begin
    // divisor sign follows the direction flag
    addend         = df ? (~b + ONE) : b;
    {carry, sum}   = {1'b0, a} + {1'b0, addend};
    // two independent toggles: missing carry, prior negative sign
    df_step        = df ^ ~carry ^ n;
    fix_sum        = a + b;

    res_nxt = a;
    q_nxt   = q;
    df_nxt  = df;
    n_nxt   = n;
    case (kind)
      STEP_INIT: begin
        res_nxt = {b[W-2:0], q[W-1]};
        q_nxt   = {q[W-2:0], 1'b0};
        df_nxt  = 1'b1;
        n_nxt   = b[W-1];
      end
      STEP_MID: begin
        res_nxt = {sum[W-2:0], q[W-1]};
        q_nxt   = {q[W-2:0], df_step};
        df_nxt  = df_step;
        n_nxt   = sum[W-1];
      end
      STEP_LAST: begin
        res_nxt = sum;
        q_nxt   = {q[W-2:0], df_step};
        df_nxt  = df_step;
        n_nxt   = sum[W-1];
      end
      default: begin
        res_nxt = df ? a : fix_sum;
      end
    endcase
  end

endmodule

// File: rtl/dstep_regs.sv
module dstep_regs
  import dstep_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_q,
  input  logic [W-1:0] load_val,
  input  logic         sr_we,
  input  logic         sr_sel,
  input  logic [W-1:0] sr_wdata,
  input  logic         step_en,
  input  logic [W-1:0] res_nxt,
  input  logic [W-1:0] q_nxt,
  input  logic         df_nxt,
  input  logic         n_nxt,
  output logic [W-1:0] res,
  output logic [W-1:0] q,
  output logic         df,
  output logic         n
);

  // priority: dividend load, then special-register write, then step
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res <= '0;
      q   <= '0;
      df  <= 1'b0;
      n   <= 1'b0;
    end else if (load_q) begin
      q <= load_val;
    end else if (sr_we) begin
      if (sr_sel == SR_SEL_FLAGS) begin
        df <= sr_wdata[FLAG_DF_BIT];
        n  <= sr_wdata[FLAG_N_BIT];
      end else begin
        q <= sr_wdata;
      end
    end else if (step_en) begin
      res <= res_nxt;
      q   <= q_nxt;
      df  <= df_nxt;
      n   <= n_nxt;
    end
  end

endmodule

// File: rtl/dstep_seq.sv
module dstep_seq
  import dstep_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_divisor,
  output logic         out_valid,
  input  logic         out_ready,
  output logic         accept,
  output logic         active,
  output step_kind_e   kind,
  output logic [W-1:0] b_op
);

  localparam int MID_STEPS = W - 1;
  localparam int CW        = (MID_STEPS > 1) ? $clog2(MID_STEPS) : 1;
  localparam logic [CW-1:0] MID_END = CW'(MID_STEPS - 1);

  seq_state_e   state;
  logic [CW-1:0] cnt;
  logic [W-1:0]  divisor_q;

  always_comb begin
    in_ready  = (state == SQ_IDLE);
    out_valid = (state == SQ_DONE);
    accept    = in_valid && in_ready;
    active    = 1'b1;
    kind      = STEP_MID;
    b_op      = divisor_q;
    case (state)
      SQ_INIT: begin
        kind = STEP_INIT;
        b_op = '0;
      end
      SQ_MID:  kind = STEP_MID;
      SQ_LAST: kind = STEP_LAST;
      SQ_FIX:  kind = STEP_FIX;
      default: active = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      cnt       <= '0;
      divisor_q <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (in_valid) begin
          state     <= SQ_INIT;
          divisor_q <= in_divisor;
        end
        SQ_INIT: begin
          state <= SQ_MID;
          cnt   <= '0;
        end
        SQ_MID: begin
          if (cnt == MID_END) state <= SQ_LAST;
          else cnt <= cnt + 1'b1;
        end
        SQ_LAST: state <= SQ_FIX;
        SQ_FIX:  state <= SQ_DONE;
        SQ_DONE: if (out_ready) state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dstep_unit.sv
module dstep_unit
  import dstep_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_req,
  input  logic [1:0]   step_kind,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         sr_we,
  input  logic         sr_sel,
  input  logic [W-1:0] sr_wdata,
  output logic [W-1:0] res,
  output logic [W-1:0] q,
  output logic         df,
  output logic         n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_dividend,
  input  logic [W-1:0] in_divisor,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_quot,
  output logic [W-1:0] out_rem
);

  logic         accept;
  logic         seq_active;
  step_kind_e   seq_kind;
  logic [W-1:0] seq_b;

  logic         ext_ok;
  logic         sr_do;
  logic         ext_step;
  logic         step_en;
  step_kind_e   alu_kind;
  logic [W-1:0] alu_a;
  logic [W-1:0] alu_b;

  logic [W-1:0] res_nxt;
  logic [W-1:0] q_nxt;
  logic         df_nxt;
  logic         n_nxt;

  dstep_seq #(.W(W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_divisor (in_divisor),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .accept     (accept),
    .active     (seq_active),
    .kind       (seq_kind),
    .b_op       (seq_b)
  );

  // external access only while idle and not starting a division
  assign ext_ok   = in_ready && !accept;
  assign sr_do    = sr_we && ext_ok;
  assign ext_step = step_req && ext_ok && !sr_we;
  assign step_en  = ext_step || seq_active;

  assign alu_kind = seq_active ? seq_kind : step_kind_e'(step_kind);
  assign alu_a    = seq_active ? res      : op_a;
  assign alu_b    = seq_active ? seq_b    : op_b;

  dstep_alu #(.W(W)) u_alu (
    .kind    (alu_kind),
    .a       (alu_a),
    .b       (alu_b),
    .q       (q),
    .df      (df),
    .n       (n),
    .res_nxt (res_nxt),
    .q_nxt   (q_nxt),
    .df_nxt  (df_nxt),
    .n_nxt   (n_nxt)
  );

  dstep_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_q   (accept),
    .load_val (in_dividend),
    .sr_we    (sr_do),
    .sr_sel   (sr_sel),
    .sr_wdata (sr_wdata),
    .step_en  (step_en),
    .res_nxt  (res_nxt),
    .q_nxt    (q_nxt),
    .df_nxt   (df_nxt),
    .n_nxt    (n_nxt),
    .res      (res),
    .q        (q),
    .df       (df),
    .n        (n)
  );

  assign out_quot = q;
  assign out_rem  = res;

endmodule

// File: rtl/dstep_unit_chk.sv
module dstep_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         step_req,
  input logic [1:0]   step_kind,
  input logic [W-1:0] op_b,
  input logic         sr_we,
  input logic         sr_sel,
  input logic [W-1:0] sr_wdata,
  input logic [W-1:0] res,
  input logic [W-1:0] q,
  input logic         df,
  input logic         n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_quot,
  input logic [W-1:0] out_rem
);

  logic ext_go;
  assign ext_go = step_req && in_ready && !in_valid && !sr_we;

  assert_init_seed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_go && step_kind == 2'd0) |=>
      (df && n == $past(op_b[W-1]) && !q[0] &&
       res == {$past(op_b[W-2:0]), $past(q[W-1])}));

  assert_mid_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_go && step_kind == 2'd1) |=>
      (q[0] == df && q[W-1:1] == $past(q[W-2:0]) && res[0] == $past(q[W-1])));

  assert_last_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_go && step_kind == 2'd2) |=> (q[0] == df && n == res[W-1]));

  assert_fix_keeps_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_go && step_kind == 2'd3) |=> ($stable(q) && $stable(df) && $stable(n)));

  assert_flag_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_we && sr_sel && in_ready && !in_valid) |=>
      (df == $past(sr_wdata[0]) && n == $past(sr_wdata[1]) && $stable(res)));

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_quot) && $stable(out_rem)));

  assert_busy_no_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_busy_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(df) && $stable(n)));

endmodule

bind dstep_unit dstep_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .step_req  (step_req),
  .step_kind (step_kind),
  .op_b      (op_b),
  .sr_we     (sr_we),
  .sr_sel    (sr_sel),
  .sr_wdata  (sr_wdata),
  .res       (res),
  .q         (q),
  .df        (df),
  .n         (n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_quot  (out_quot),
  .out_rem   (out_rem)
);

// File: tb/dstep_unit_tb_top.sv
`timescale 1ns/1ps
module dstep_unit_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         step_req = 1'b0;
  logic [1:0]   step_kind = 2'd0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic         sr_we = 1'b0, sr_sel = 1'b0;
  logic [W-1:0] sr_wdata = '0;
  logic [W-1:0] res, q;
  logic         df, n;
  logic         in_valid = 1'b0, in_ready;
  logic [W-1:0] in_dividend = '0, in_divisor = '0;
  logic         out_valid, out_ready = 1'b0;
  logic [W-1:0] out_quot, out_rem;

  always #5 clk = ~clk;

  dstep_unit #(.W(W)) dut_i (.*);

  int    total = 0;
  int    bad = 0;
  string cur_tag = "R1";

  // ---------------- behavioural reference ----------------
  logic [W-1:0] m_res, m_q, m_div;
  logic         m_df, m_n;
  int           m_phase;   // -1 idle, 0..W+1 stepping, W+2 result waiting

  task automatic model_step(input int kind, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] t, s;
    longint       wide;
    logic         c, nd;
    if (kind == 0) begin
      m_res = {b[W-2:0], m_q[W-1]};
      m_q   = m_q << 1;
      m_df  = 1'b1;
      m_n   = b[W-1];
    end else if (kind == 3) begin
      m_res = m_df ? a : a + b;
    end else begin
      t    = m_df ? (0 - b) : b;
      wide = longint'({1'b0, a}) + longint'({1'b0, t});
      s    = wide[W-1:0];
      c    = wide[W];
      nd   = m_df;
      if (!c)  nd = !nd;
      if (m_n) nd = !nd;
      m_res = (kind == 1) ? {s[W-2:0], m_q[W-1]} : s;
      m_q   = {m_q[W-2:0], nd};
      m_df  = nd;
      m_n   = s[W-1];
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_res = '0; m_q = '0; m_div = '0; m_df = 0; m_n = 0; m_phase = -1;
    end else if (m_phase == -1) begin
      if (in_valid) begin
        m_q = in_dividend; m_div = in_divisor; m_phase = 0;
      end else if (sr_we) begin
        if (sr_sel) begin m_df = sr_wdata[0]; m_n = sr_wdata[1]; end
        else m_q = sr_wdata;
      end else if (step_req) begin
        model_step(int'(step_kind), op_a, op_b);
      end
    end else if (m_phase <= W + 1) begin
      if (m_phase == 0)        model_step(0, m_res, '0);
      else if (m_phase < W)    model_step(1, m_res, m_div);
      else if (m_phase == W)   model_step(2, m_res, m_div);
      else                     model_step(3, m_res, m_div);
      m_phase++;
    end else if (out_ready) begin
      m_phase = -1;
    end
  end

  task automatic check(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    check(cur_tag, "res", res, m_res);
    check(cur_tag, "q", q, m_q);
    check(cur_tag, "flags", {30'd0, n, df}, {30'd0, m_n, m_df});
    check(cur_tag, "in_ready", {31'd0, in_ready}, {31'd0, (m_phase == -1)});
    check(cur_tag, "out_valid", {31'd0, out_valid}, {31'd0, (m_phase == W + 2)});
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(); @(negedge clk); endtask

  task automatic do_step(input logic [1:0] k, input logic [W-1:0] a, input logic [W-1:0] b);
    step_req = 1; step_kind = k; op_a = a; op_b = b;
    cyc();
    step_req = 0;
  endtask

  task automatic sr_write(input logic sel, input logic [W-1:0] d);
    sr_we = 1; sr_sel = sel; sr_wdata = d;
    cyc();
    sr_we = 0;
  endtask

  task automatic sw_divide(input logic [W-1:0] x, input logic [W-1:0] d);
    sr_write(1'b0, x);
    do_step(2'd0, '0, '0);
    for (int i = 0; i < W - 1; i++) do_step(2'd1, res, d);
    do_step(2'd2, res, d);
    do_step(2'd3, res, d);
    check("R5", "sw quotient", q, x / d);
    check("R5", "sw remainder", res, x % d);
  endtask

  task automatic hw_divide(input logic [W-1:0] x, input logic [W-1:0] d, input int stall, input bit poke);
    int lat;
    in_dividend = x; in_divisor = d; in_valid = 1;
    if (poke) begin sr_we = 1; sr_sel = 0; sr_wdata = 32'hFFFF0000; step_req = 1; end
    cyc();
    in_valid = 0; sr_we = 0; step_req = 0;
    lat = 1;
    while (!out_valid && lat < 200) begin
      if (poke && lat == 5) begin step_req = 1; step_kind = 2'd0; op_b = 32'h80000000; end
      if (poke && lat == 9) begin step_req = 0; sr_we = 1; sr_sel = 1; sr_wdata = 32'h3; end
      if (poke && lat == 10) sr_we = 0;
      cyc();
      lat++;
    end
    sr_we = 0; step_req = 0;
    check("R8", "latency", lat, W + 3);
    for (int i = 0; i < stall; i++) begin
      if (poke) step_req = 1;
      cyc();
    end
    step_req = 0;
    check("R8", "quotient", out_quot, x / d);
    check("R8", "remainder", out_rem, x % d);
    check("R9", "held valid", {31'd0, out_valid}, 32'd1);
    out_ready = 1;
    cyc();
    out_ready = 0;
    check("R9", "ready back", {31'd0, in_ready}, 32'd1);
  endtask

  // ---------------- watchdog ----------------
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp<50000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- sequence ----------------
  initial begin
    cur_tag = "R1";
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    check("R1", "reset res", res, '0);
    check("R1", "reset q", q, '0);

    cur_tag = "R6";
    sr_write(1'b0, 32'h12345678);
    check("R6", "q write", q, 32'h12345678);
    sr_write(1'b1, 32'h2);
    check("R6", "flags write", {30'd0, n, df}, 32'h2);
    step_req = 1; step_kind = 2'd0; op_b = 32'hFFFFFFFF;
    sr_write(1'b1, 32'h0);
    step_req = 0;
    check("R6", "step dropped", res, '0);

    cur_tag = "R7";
    for (int i = 0; i < 6; i++) begin
      op_a = 32'h1111 * i; op_b = ~op_a; step_kind = 2'(i);
      cyc();
    end
    check("R7", "held q", q, 32'h12345678);

    cur_tag = "R2";
    do_step(2'd0, 32'h5, 32'h80000001);
    check("R2", "init res", res, 32'h00000002);
    check("R2", "init flags", {30'd0, n, df}, 32'h3);
    do_step(2'd0, 32'h0, 32'h40000000);

    cur_tag = "R3";
    for (int f = 0; f < 4; f++) begin
      sr_write(1'b1, 32'(f));
      do_step(2'd1, 32'h70000000, 32'h90000000);
      sr_write(1'b1, 32'(f));
      do_step(2'd1, 32'h00000003, 32'h00000009);
    end

    cur_tag = "R4";
    sr_write(1'b1, 32'h1);
    do_step(2'd2, 32'h10, 32'h30);
    check("R4", "last res", res, 32'hFFFFFFE0);
    sr_write(1'b1, 32'h0);
    do_step(2'd2, 32'h10, 32'h30);

    cur_tag = "R5";
    sr_write(1'b1, 32'h1);
    do_step(2'd3, 32'hAB, 32'h100);
    check("R5", "fix df1", res, 32'hAB);
    sr_write(1'b1, 32'h0);
    do_step(2'd3, 32'hFFFFFFF0, 32'h20);
    check("R5", "fix df0", res, 32'h10);
    sw_divide(32'd100, 32'd7);
    sw_divide(32'hFFFFFFFF, 32'h80000000);

    cur_tag = "R8";
    hw_divide(32'd100, 32'd7, 0, 0);
    hw_divide(32'hFFFFFFFF, 32'd1, 0, 0);
    hw_divide(32'd5, 32'd9, 0, 0);
    hw_divide(32'h80000000, 32'hFFFFFFFF, 0, 0);
    hw_divide(32'hDEADBEEF, 32'h00010001, 0, 0);
    hw_divide(32'd0, 32'd5, 0, 0);
    cur_tag = "R9";
    hw_divide(32'd123456789, 32'd1000, 4, 0);
    cur_tag = "R10";
    hw_divide(32'hFFFFFFFF, 32'hC0000001, 3, 1);
    hw_divide(32'hFFFFFFFE, 32'hFFFFFFFF, 2, 1);

    repeat (2) cyc();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule